// File: doc/BRIEF.md
# Load/Store Queue Slot Allocator with Tail Squash

This block tracks slot ownership for the load queue and the store queue of an out-of-order core. Each queue is a ring buffer with one slot more than its capacity, so a full ring and an empty ring have different pointer states. Dispatch offers one memory operation per cycle with its sequence number. The block gives the operation a slot in its own ring and returns, as a cross-link, the current tail of the other ring. It reports how many more operations of either kind can still be accepted.

Loads leave from the head when commit names the youngest committed sequence number. Stores are first marked as cleared to write back, once they are committed. They then leave from the head one at a time through a release strobe. A squash names a sequence number. The block then walks both rings backward from the tail, one entry per ring per cycle, and drops every younger entry. In the store ring the walk stops early at a marked store, because that store is already committed. While the walk runs, a busy flag holds off all other updates.

Sequence numbers are treated as unsigned and are assumed not to wrap within the lifetime of the entries held.

Top module: `lsq_alloc`

## Requirements
- R1: The load ring holds at most LQ_CAP entries and the store ring at most SQ_CAP entries. The physical ring sizes are LQ_CAP+1 and SQ_CAP+1. An insert into a full ring changes no state, and `ins_err` is high in the following cycle. An accepted insert leaves `ins_err` low in the following cycle.
- R2: `ins_lq_idx` always shows the load-ring tail and `ins_sq_idx` always shows the store-ring tail. A load takes slot `ins_lq_idx` and is linked to `ins_sq_idx`. A store takes slot `ins_sq_idx` and is linked to `ins_lq_idx`. An accepted insert advances only the tail of its own ring, by one, and raises that ring's used count by one at the next edge.
- R3: `free_slots` equals min(LQ_CAP+1-`lq_used`, SQ_CAP+1-`sq_used`) minus 1.
- R4: A ring index advances from size-1 to 0. During a squash it steps back from 0 to size-1.
- R5: A load commit with bound B removes, in a single cycle, every load counted from the head up to the first one whose sequence number exceeds B. A load with sequence number equal to B is removed.
- R6: A squash at point P removes, one per cycle from the tail, every load whose sequence number is greater than P. The walk stops at the first load with a number at or below P, and the load-ring tail moves back by the number of loads removed.
- R7: In the store ring the squash removes stores younger than P from the tail. The walk stops at the first store that is marked, even if that store is younger than P, or at the first store with a number at or below P.
- R8: A mark with bound B marks every held store whose number is at or below B. A release removes the head store only if it is marked. A release with an unmarked head, or with an empty store ring, changes nothing.
- R9: `busy` rises in the cycle after a squash is accepted and stays high for max(loads removed, stores removed)+1 cycles. While it is high, inserts are rejected with `ins_err`, and load commits, marks, releases and further squashes are ignored.
- R10: After reset both rings are empty, both indices are 0, `free_slots` is min(LQ_CAP, SQ_CAP), and `busy` and `ins_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Dispatch offers one memory operation |
| ins_store | input | 1 | 1 = store, 0 = load |
| ins_seq | input | SEQ_W | Sequence number of the offered operation |
| ins_lq_idx | output | $clog2(LQ_CAP+1) | Load-ring tail: slot of a load, link of a store |
| ins_sq_idx | output | $clog2(SQ_CAP+1) | Store-ring tail: slot of a store, link of a load |
| ins_err | output | 1 | Previous cycle's insert was rejected |
| ld_commit_valid | input | 1 | Retire committed loads from the head |
| ld_commit_seq | input | SEQ_W | Youngest committed sequence number |
| st_mark_valid | input | 1 | Mark committed stores as cleared to write back |
| st_mark_seq | input | SEQ_W | Youngest committed sequence number |
| st_release | input | 1 | Remove the head store if it is marked |
| squash_valid | input | 1 | Start a squash |
| squash_seq | input | SEQ_W | Squash point; younger entries are removed |
| busy | output | 1 | Squash walk in progress |
| free_slots | output | $clog2(min(LQ_CAP,SQ_CAP)+1) | Operations of either kind that still fit |
| lq_used | output | $clog2(LQ_CAP+2) | Loads held |
| sq_used | output | $clog2(SQ_CAP+2) | Stores held |

## Verification
Directed sequences fill each ring to its limit, which tells the full comparison apart from an off-by-one sentinel. They also push both tails across the wrap point in both directions. Squashes are aimed so that the load walk and the store walk take different lengths, so the busy duration shows whether both walks are awaited. One store squash has a younger marked store in its path, which separates the mark stop from the plain sequence-number stop. Commit bounds fall exactly on a held sequence number to check the at-or-below comparison. A long random mix of inserts, commits, marks, releases and squashes is then compared against a bench model of both rings after every operation.

// File: rtl/lsq_alloc_pkg.sv
package lsq_alloc_pkg;

    // Step a ring index forward, wrapping to 0 at the physical size.
    function automatic int ring_next(int i, int n);
        return (i + 1 >= n) ? 0 : i + 1;
    endfunction

    // Step a ring index backward, wrapping below 0 to the last slot.
    function automatic int ring_prev(int i, int n);
        return (i == 0) ? n - 1 : i - 1;
    endfunction

    function automatic int min_of(int a, int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/lsq_alloc_ring.sv
module lsq_alloc_ring
    import lsq_alloc_pkg::*;
#(
    parameter int PHYS  = 9,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(PHYS),
    localparam int CNT_W = $clog2(PHYS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [SEQ_W-1:0] push_seq_i,
    input  logic             commit_i,
    input  logic [SEQ_W-1:0] commit_seq_i,
    input  logic             mark_i,
    input  logic [SEQ_W-1:0] mark_seq_i,
    input  logic             release_i,
    input  logic             walk_i,
    input  logic [SEQ_W-1:0] walk_point_i,
    output logic [IDX_W-1:0] tail_o,
    output logic [CNT_W-1:0] used_o,
    output logic             full_o,
    output logic             walk_stop_o
);

    typedef struct packed {
        logic [PHYS-1:0]            valid;
        logic [PHYS-1:0]            mark;
        logic [PHYS-1:0][SEQ_W-1:0] seq;
        logic [IDX_W-1:0]           head;
        logic [IDX_W-1:0]           tail;
        logic [CNT_W-1:0]           used;
    } ring_t;

    ring_t ring_q, ring_d;
    logic [IDX_W-1:0] last_w;

    always_comb begin
        logic [IDX_W-1:0] pos;
        logic             go;
        int               n_pop;
        int               n_push;
        int               n_walk;

        ring_d = ring_q;
        n_pop  = 0;
        n_push = 0;
        n_walk = 0;
        last_w = IDX_W'(ring_prev(int'(ring_q.tail), PHYS));

        // Walk stops on empty ring, on an old-enough entry, or on a committed one.
        walk_stop_o = (ring_q.used == '0) ||
                      (ring_q.seq[last_w] <= walk_point_i) ||
                      ring_q.mark[last_w];

        // Multi-entry retire from the head bounded by sequence number.
        pos = ring_q.head;
        go  = commit_i;
        for (int i = 0; i < PHYS; i++) begin
            if (go && (i < int'(ring_q.used)) && (ring_q.seq[pos] <= commit_seq_i)) begin
                ring_d.valid[pos] = 1'b0;
                ring_d.mark[pos]  = 1'b0;
                n_pop++;
                pos = IDX_W'(ring_next(int'(pos), PHYS));
            end else begin
                go = 1'b0;
            end
        end
        ring_d.head = pos;

        // Marking of committed entries.
        if (mark_i) begin
            for (int k = 0; k < PHYS; k++) begin
                if (ring_q.valid[k] && (ring_q.seq[k] <= mark_seq_i)) begin
                    ring_d.mark[k] = 1'b1;
                end
            end
        end

        // Single release of a marked head entry.
        if (release_i && (ring_q.used != '0) && ring_q.mark[ring_q.head]) begin
            ring_d.valid[ring_q.head] = 1'b0;
            ring_d.mark[ring_q.head]  = 1'b0;
            ring_d.head = IDX_W'(ring_next(int'(ring_q.head), PHYS));
            n_pop++;
        end

        if (push_i) begin
            ring_d.valid[ring_q.tail] = 1'b1;
            ring_d.mark[ring_q.tail]  = 1'b0;
            ring_d.seq[ring_q.tail]   = push_seq_i;
            ring_d.tail = IDX_W'(ring_next(int'(ring_q.tail), PHYS));
            n_push = 1;
        end

        if (walk_i && !walk_stop_o) begin
            ring_d.valid[last_w] = 1'b0;
            ring_d.mark[last_w]  = 1'b0;
            ring_d.tail = last_w;
            n_walk = 1;
        end

        ring_d.used = CNT_W'(int'(ring_q.used) + n_push - n_pop - n_walk);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign tail_o = ring_q.tail;
    assign used_o = ring_q.used;
    assign full_o = (IDX_W'(ring_next(int'(ring_q.tail), PHYS)) == ring_q.head);

    // R1: occupancy never exceeds the capacity (one slot kept free)
    p_used_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(used_o) <= PHYS - 1);

    // R1: pointer-based full agrees with the occupancy counter
    p_full_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        full_o == (int'(used_o) == PHYS - 1));

    // R6: an active walk step removes exactly one entry
    p_walk_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_i && !walk_stop_o) |=> (int'(used_o) == int'($past(used_o)) - 1));

    // R1: the owner never pushes into a full ring
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

endmodule

// File: rtl/lsq_alloc_free.sv
module lsq_alloc_free
    import lsq_alloc_pkg::*;
#(
    parameter int LQ_PHYS = 9,
    parameter int SQ_PHYS = 7,
    localparam int LQ_CW  = $clog2(LQ_PHYS + 1),
    localparam int SQ_CW  = $clog2(SQ_PHYS + 1),
    localparam int FREE_W = $clog2(min_of(LQ_PHYS, SQ_PHYS))
) (
    input  logic [LQ_CW-1:0]  lq_used_i,
    input  logic [SQ_CW-1:0]  sq_used_i,
    output logic [FREE_W-1:0] free_o
);

    always_comb begin
        int lq_room;
        int sq_room;
        lq_room = LQ_PHYS - int'(lq_used_i);
        sq_room = SQ_PHYS - int'(sq_used_i);
        // The sentinel slot of the tighter ring is never offered.
        free_o  = FREE_W'(min_of(lq_room, sq_room) - 1);
    end

endmodule

// File: rtl/lsq_alloc.sv
module lsq_alloc
    import lsq_alloc_pkg::*;
#(
    parameter int LQ_CAP = 8,
    parameter int SQ_CAP = 6,
    parameter int SEQ_W  = 16,
    localparam int LQ_PHYS = LQ_CAP + 1,
    localparam int SQ_PHYS = SQ_CAP + 1,
    localparam int LQ_IW   = $clog2(LQ_PHYS),
    localparam int SQ_IW   = $clog2(SQ_PHYS),
    localparam int LQ_CW   = $clog2(LQ_PHYS + 1),
    localparam int SQ_CW   = $clog2(SQ_PHYS + 1),
    localparam int FREE_W  = $clog2(min_of(LQ_PHYS, SQ_PHYS))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic              ins_store,
    input  logic [SEQ_W-1:0]  ins_seq,
    output logic [LQ_IW-1:0]  ins_lq_idx,
    output logic [SQ_IW-1:0]  ins_sq_idx,
    output logic              ins_err,
    input  logic              ld_commit_valid,
    input  logic [SEQ_W-1:0]  ld_commit_seq,
    input  logic              st_mark_valid,
    input  logic [SEQ_W-1:0]  st_mark_seq,
    input  logic              st_release,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              busy,
    output logic [FREE_W-1:0] free_slots,
    output logic [LQ_CW-1:0]  lq_used,
    output logic [SQ_CW-1:0]  sq_used
);

    typedef struct packed {
        logic             busy;
        logic [SEQ_W-1:0] point;
        logic             err;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic lq_full, sq_full, lq_stop, sq_stop;
    logic ins_ok, lq_push, sq_push, upd_open;

    always_comb begin
        ctl_d    = ctl_q;
        upd_open = !ctl_q.busy;
        ins_ok   = ins_valid && upd_open && !squash_valid &&
                   (ins_store ? !sq_full : !lq_full);
        lq_push  = ins_ok && !ins_store;
        sq_push  = ins_ok && ins_store;

        ctl_d.err = ins_valid && !ins_ok;

        if (!ctl_q.busy && squash_valid) begin
            ctl_d.busy  = 1'b1;
            ctl_d.point = squash_seq;
        end else if (ctl_q.busy && lq_stop && sq_stop) begin
            ctl_d.busy  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lsq_alloc_ring #(.PHYS(LQ_PHYS), .SEQ_W(SEQ_W)) u_load_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (lq_push),
        .push_seq_i   (ins_seq),
        .commit_i     (ld_commit_valid && upd_open),
        .commit_seq_i (ld_commit_seq),
        .mark_i       (1'b0),
        .mark_seq_i   ('0),
        .release_i    (1'b0),
        .walk_i       (ctl_q.busy),
        .walk_point_i (ctl_q.point),
        .tail_o       (ins_lq_idx),
        .used_o       (lq_used),
        .full_o       (lq_full),
        .walk_stop_o  (lq_stop)
    );

    lsq_alloc_ring #(.PHYS(SQ_PHYS), .SEQ_W(SEQ_W)) u_store_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (sq_push),
        .push_seq_i   (ins_seq),
        .commit_i     (1'b0),
        .commit_seq_i ('0),
        .mark_i       (st_mark_valid && upd_open),
        .mark_seq_i   (st_mark_seq),
        .release_i    (st_release && upd_open),
        .walk_i       (ctl_q.busy),
        .walk_point_i (ctl_q.point),
        .tail_o       (ins_sq_idx),
        .used_o       (sq_used),
        .full_o       (sq_full),
        .walk_stop_o  (sq_stop)
    );

    lsq_alloc_free #(.LQ_PHYS(LQ_PHYS), .SQ_PHYS(SQ_PHYS)) u_free (
        .lq_used_i (lq_used),
        .sq_used_i (sq_used),
        .free_o    (free_slots)
    );

    assign busy    = ctl_q.busy;
    assign ins_err = ctl_q.err;

    // R1: a load offered to a full load ring is flagged next cycle
    p_err_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_store && (int'(lq_used) == LQ_CAP)) |=> ins_err);

    // R9: any insert offered during a squash walk is flagged
    p_busy_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ins_valid) |=> ins_err);

    // R3: reported room never exceeds either capacity
    p_free_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(free_slots) <= LQ_CAP) && (int'(free_slots) <= SQ_CAP));

    // R2: an accepted load raises the load count by one
    p_load_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_store && !busy && !squash_valid && !ld_commit_valid &&
         (int'(lq_used) < LQ_CAP)) |=> (int'(lq_used) == int'($past(lq_used)) + 1));

    // R9: no occupancy grows while the walk runs
    p_busy_no_grow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (int'(lq_used) <= int'($past(lq_used))) &&
                 (int'(sq_used) <= int'($past(sq_used))));

endmodule

// File: tb/lsq_alloc_tb_top.sv
module lsq_alloc_tb_top;

    localparam int LQ_CAP = 8;
    localparam int SQ_CAP = 6;
    localparam int SEQ_W  = 16;
    localparam int LQP    = LQ_CAP + 1;
    localparam int SQP    = SQ_CAP + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 1'b0, ins_store = 1'b0;
    logic [SEQ_W-1:0] ins_seq = '0;
    logic [$clog2(LQP)-1:0] ins_lq_idx;
    logic [$clog2(SQP)-1:0] ins_sq_idx;
    logic ins_err;
    logic ld_commit_valid = 1'b0;
    logic [SEQ_W-1:0] ld_commit_seq = '0;
    logic st_mark_valid = 1'b0;
    logic [SEQ_W-1:0] st_mark_seq = '0;
    logic st_release = 1'b0;
    logic squash_valid = 1'b0;
    logic [SEQ_W-1:0] squash_seq = '0;
    logic busy;
    logic [2:0] free_slots;
    logic [$clog2(LQP+1)-1:0] lq_used;
    logic [$clog2(SQP+1)-1:0] sq_used;

    always #4 clk = ~clk;

    lsq_alloc #(.LQ_CAP(LQ_CAP), .SQ_CAP(SQ_CAP), .SEQ_W(SEQ_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_store(ins_store), .ins_seq(ins_seq),
        .ins_lq_idx(ins_lq_idx), .ins_sq_idx(ins_sq_idx), .ins_err(ins_err),
        .ld_commit_valid(ld_commit_valid), .ld_commit_seq(ld_commit_seq),
        .st_mark_valid(st_mark_valid), .st_mark_seq(st_mark_seq),
        .st_release(st_release),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .busy(busy), .free_slots(free_slots),
        .lq_used(lq_used), .sq_used(sq_used)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Reference model of both rings.
    int m_lseq [LQP];
    int m_lh = 0, m_lt = 0, m_lu = 0;
    int m_sseq [SQP];
    bit m_smk  [SQP];
    int m_sh = 0, m_st = 0, m_su = 0;
    int next_seq = 1;

    function automatic int nx(int i, int n); return (i + 1 >= n) ? 0 : i + 1; endfunction
    function automatic int pv(int i, int n); return (i == 0) ? n - 1 : i - 1; endfunction
    function automatic int exp_free();
        int a, b;
        a = LQP - m_lu;
        b = SQP - m_su;
        return ((a < b) ? a : b) - 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk({req, " lq_used"}, int'(lq_used), m_lu);
        chk({req, " sq_used"}, int'(sq_used), m_su);
        chk("R3 free_slots", int'(free_slots), exp_free());
        chk({req, " lq tail"}, int'(ins_lq_idx), m_lt);
        chk({req, " sq tail"}, int'(ins_sq_idx), m_st);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic op_insert(bit st);
        bit acc;
        bit wrap;
        acc  = st ? (m_su < SQ_CAP) : (m_lu < LQ_CAP);
        wrap = st ? (m_st == SQP - 1) : (m_lt == LQP - 1);
        chk("R2 load idx before insert", int'(ins_lq_idx), m_lt);
        chk("R2 store idx before insert", int'(ins_sq_idx), m_st);
        ins_valid = 1'b1;
        ins_store = st;
        ins_seq   = SEQ_W'(next_seq);
        step();
        ins_valid = 1'b0;
        if (acc) begin
            if (st) begin
                m_sseq[m_st] = next_seq; m_smk[m_st] = 1'b0;
                m_st = nx(m_st, SQP); m_su++;
            end else begin
                m_lseq[m_lt] = next_seq;
                m_lt = nx(m_lt, LQP); m_lu++;
            end
            if (wrap) chk("R4 tail wraps to 0", st ? int'(ins_sq_idx) : int'(ins_lq_idx), 0);
        end
        next_seq++;
        chk("R1 ins_err", int'(ins_err), acc ? 0 : 1);
        check_all("R2");
    endtask

    task automatic op_commit(int bound);
        ld_commit_valid = 1'b1;
        ld_commit_seq   = SEQ_W'(bound);
        step();
        ld_commit_valid = 1'b0;
        while (m_lu != 0 && m_lseq[m_lh] <= bound) begin
            m_lh = nx(m_lh, LQP); m_lu--;
        end
        check_all("R5");
    endtask

    task automatic op_mark(int bound);
        int p;
        st_mark_valid = 1'b1;
        st_mark_seq   = SEQ_W'(bound);
        step();
        st_mark_valid = 1'b0;
        p = m_sh;
        for (int i = 0; i < m_su; i++) begin
            if (m_sseq[p] <= bound) m_smk[p] = 1'b1;
            p = nx(p, SQP);
        end
        check_all("R8");
    endtask

    task automatic op_release();
        st_release = 1'b1;
        step();
        st_release = 1'b0;
        if (m_su != 0 && m_smk[m_sh]) begin
            m_smk[m_sh] = 1'b0;
            m_sh = nx(m_sh, SQP); m_su--;
        end
        check_all("R8");
    endtask

    task automatic op_squash(int point, bit poke);
        int rl, rs, cnt, expc;
        bit lwrap;
        squash_valid = 1'b1;
        squash_seq   = SEQ_W'(point);
        step();
        squash_valid = 1'b0;
        rl = 0; rs = 0; lwrap = 0;
        while (m_lu != 0 && m_lseq[pv(m_lt, LQP)] > point) begin
            if (m_lt == 0) lwrap = 1;
            m_lt = pv(m_lt, LQP); m_lu--; rl++;
        end
        while (m_su != 0 && !m_smk[pv(m_st, SQP)] && m_sseq[pv(m_st, SQP)] > point) begin
            m_st = pv(m_st, SQP); m_su--; rs++;
        end
        expc = ((rl > rs) ? rl : rs) + 1;
        cnt = 0;
        while (busy && cnt < 40) begin
            cnt++;
            if (poke && cnt == 1) begin
                ins_valid = 1'b1; ins_store = 1'b0; ins_seq = SEQ_W'(next_seq);
                ld_commit_valid = 1'b1; ld_commit_seq = '1;
                st_release = 1'b1;
            end
            step();
            if (poke && cnt == 1) begin
                ins_valid = 1'b0; ld_commit_valid = 1'b0; st_release = 1'b0;
                next_seq++;
                chk("R9 insert during busy flagged", int'(ins_err), 1);
            end
        end
        chk("R9 busy cycles", cnt, expc);
        check_all("R6/R7");
        if (lwrap) chk("R4 tail steps back past 0", int'(ins_lq_idx), m_lt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion (all R)");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int sq_hold;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check_all("R10");
        chk("R10 busy", int'(busy), 0);
        chk("R10 ins_err", int'(ins_err), 0);

        // R1/R2: fill the load ring, then overflow
        for (int i = 0; i < LQ_CAP; i++) op_insert(1'b0);
        op_insert(1'b0);
        chk("R1 load ring full", int'(lq_used), LQ_CAP);

        // R6/R7/R9: uneven squash with a poke while busy
        for (int i = 0; i < 3; i++) op_insert(1'b1);
        op_squash(6, 1'b1);

        // R7/R8: marked store stops the squash walk
        for (int i = 0; i < 2; i++) op_insert(1'b1);
        op_mark(next_seq - 1);
        for (int i = 0; i < 2; i++) op_insert(1'b1);
        sq_hold = m_su;
        op_squash(0, 1'b0);
        chk("R7 marked stores survive", int'(sq_used), 2);
        op_release();
        op_release();
        op_release();
        op_insert(1'b1);
        op_release();
        chk("R8 unmarked head stays", int'(sq_used), 1);
        op_mark(next_seq);
        op_release();

        // R5: commit bound equal to a held load
        for (int i = 0; i < 5; i++) op_insert(1'b0);
        op_commit(m_lseq[nx(m_lh, LQP)]);
        chk("R5 partial commit", int'(lq_used), 3);
        op_commit(next_seq);

        // R4: advance the load tail to 0 and squash back across it
        while (m_lt != LQP - 2) begin
            op_insert(1'b0);
            op_commit(next_seq);
        end
        for (int i = 0; i < 4; i++) op_insert(1'b0);
        op_squash(next_seq - 4, 1'b0);
        op_commit(next_seq);

        // Random mix against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 30)      op_insert(1'b0);
            else if (r < 55) op_insert(1'b1);
            else if (r < 65) op_commit(next_seq - int'($urandom_range(0, 10)));
            else if (r < 75) op_mark(next_seq - int'($urandom_range(0, 10)));
            else if (r < 87) op_release();
            else             op_squash(next_seq - int'($urandom_range(0, 9)), r[0]);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule